// File: doc/BRIEF.md
# SCSI Controller Register File and Command Decoder

This block is the host-facing register bank of a SCSI protocol controller. A processor reaches sixteen byte-wide registers through a simple synchronous read/write port. The register index is taken from the byte address after shifting it right by a parameter. Several indices mean one thing on read and another on write. For example, index 4 reads status but writes the target bus ID, and index 5 reads the interrupt cause but a write to it is dropped.

Writing the command register decodes an opcode in bits 6:0. Bit 7 requests DMA mode, which reloads the transfer count. Purely local commands act on the status, interrupt-cause and sequence-step registers at once. Commands that need the SCSI bus (select, transfer information, status/message response) leave as one-cycle request pulses to neighbouring blocks. Those blocks report back on completion inputs, and the completion writes the result codes and raises the interrupt.

The interrupt line is a level equal to status bit 7. A read of the interrupt-cause register is the acknowledge: it returns the old cause and, in the same access, clears the cause, clears every status bit except terminal count, sets the sequence step to 4 and drops the line. A small byte FIFO sits behind index 2.

Top module: `scsi_ctl_regs`

## Requirements
- R1: After `rst`, config1 (index 8) reads 0x07, count-high (index 14) reads 0x04, status, cause, sequence step, FIFO flags, count and command readback read 0x00, and `irq` is low.
- R2: Register index is `bus_addr[ADDR_SHIFT+3:ADDR_SHIFT]`. An access with any other address bit set is ignored. Bus-ID writes (index 4) do not change the status read. Index 9 and 10 always read 0x00. Indices 8 and 11 to 15 read back what was written, and index 3 reads back the last command byte.
- R3: Writes to index 0 and 1 go to hidden holding registers and clear status bit 4 (terminal count). The readable count copies them only when a recognised command is written with bit 7 set.
- R4: A read of index 5 returns the cause value held before the access (data valid the cycle after `rd_en`). It then leaves cause 0x00, status ANDed with 0x10, sequence step 4 and `irq` low.
- R5: `irq` is high exactly when status bit 7 is set. Commands and completions that raise the interrupt set that bit.
- R6: Flush (0x01) sets cause 0x08, sequence step 0 and empties the FIFO without raising `irq`. Message accepted (0x12) sets cause 0x20, sequence step 0, empties the FIFO and raises `irq`.
- R7: Bus reset (0x03) sets cause 0x80 and raises `irq` only when config1 bit 6 is 0.
- R8: Select (0x41), select with ATN (0x42) and select with ATN and stop (0x43) pulse `sel_req` for one cycle with `sel_target` equal to bus-ID bits 2:0, `sel_atn` high for 0x42/0x43 and `sel_stop` high for 0x43. A `sel_done` with `sel_present` low sets status 0x80, cause 0x20 and sequence step 0.
- R9: A `sel_done` with `sel_present` high after 0x43 sets status 0x92, cause 0x18 and step 4, and sets `capture_mode`. After 0x41/0x42 it sets status 0x90, cause 0x18 and step 4.
- R10: Transfer information (0x10) pulses `xfer_req` with `xfer_cmd` equal to `capture_mode` and `xfer_dma` equal to opcode bit 7, then clears `capture_mode`. In DMA mode it clears status bit 4. `xfer_done` ORs 0x90 into status, sets cause 0x10 and step 0, and zeroes count low and mid.
- R11: Command-complete sequence (0x11) pulses `resp_req`. `resp_done` sets status 0x97, cause 0x08 and step 4.
- R12: Pad (0x18) sets status 0x10 (dropping `irq`), cause 0x08 and step 0. Enable selection (0x44) sets cause 0x00. NOP (0x00), set ATN (0x1a) and unlisted opcodes leave status, cause, step and counts unchanged.
- R13: Chip reset (0x02) returns every register and the FIFO to the R1 values.
- R14: FIFO writes (index 2) are stored up to `FIFO_DEPTH` bytes and further writes are dropped. Reads pop in write order, and an empty read gives 0x00. Index 7 reads the fill count.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_addr | input | ADDR_W | Byte address of the access |
| wr_en | input | 1 | Write strobe (wins over `rd_en`) |
| wr_data | input | 8 | Write data |
| rd_en | input | 1 | Read strobe |
| rd_data | output | 8 | Registered read data, valid the cycle after `rd_en` |
| irq | output | 1 | Level interrupt, equal to status bit 7 |
| sel_req | output | 1 | One-cycle select request |
| sel_atn | output | 1 | Select is with ATN |
| sel_stop | output | 1 | Select stops after the message phase |
| sel_target | output | 3 | Target ID for the select |
| sel_done | input | 1 | Select finished |
| sel_present | input | 1 | Target responded (sampled with `sel_done`) |
| xfer_req | output | 1 | One-cycle transfer-information request |
| xfer_dma | output | 1 | Transfer uses DMA |
| xfer_cmd | output | 1 | Transfer carries captured command bytes |
| xfer_done | input | 1 | Transfer finished |
| resp_req | output | 1 | One-cycle status/message response request |
| resp_done | input | 1 | Response finished |
| capture_mode | output | 1 | Command-capture state after select-and-stop |

## Verification
On every cycle the assertions check the acknowledge read: after it, cause is zero, only terminal count may remain in status, the step is 4 and the line is low. They also check that bus reset stays silent while config1 bit 6 is set, that pad and DMA transfer leave the status they require, that request pulses never overlap, and that config1 holds 0x07 after reset. The exact values each completion writes, the read-before-clear return value, the hidden count reload, FIFO ordering and overflow, and address aliasing rules can only be shown by the directed scenarios, which observe them through reads at the register port.

// File: rtl/scsi_ctl_pkg.sv
package scsi_ctl_pkg;

  localparam int REG_N = 16;

  // register indices whose meaning other logic depends on
  localparam logic [3:0] IX_CNT_LO  = 4'h0;
  localparam logic [3:0] IX_CNT_MID = 4'h1;
  localparam logic [3:0] IX_FIFO    = 4'h2;
  localparam logic [3:0] IX_CMD     = 4'h3;
  localparam logic [3:0] IX_STAT    = 4'h4;
  localparam logic [3:0] IX_CAUSE   = 4'h5;
  localparam logic [3:0] IX_STEP    = 4'h6;
  localparam logic [3:0] IX_FLAGS   = 4'h7;
  localparam logic [3:0] IX_CFG1    = 4'h8;
  localparam logic [3:0] IX_HI_BASE = 4'hB;

  localparam int HI_N  = REG_N - int'(IX_HI_BASE);
  localparam int HI_ID = 3;  // index 14 within the upper bank

  // interrupt-cause codes
  localparam logic [7:0] CAUSE_DONE  = 8'h08;
  localparam logic [7:0] CAUSE_SVC   = 8'h10;
  localparam logic [7:0] CAUSE_DISC  = 8'h20;
  localparam logic [7:0] CAUSE_BRST  = 8'h80;

  // status bits and values
  localparam int         ST_INT      = 7;
  localparam int         ST_TC       = 4;
  localparam logic [7:0] ST_TC_MASK  = 8'h10;
  localparam logic [7:0] ST_SEL_NONE = 8'h80;
  localparam logic [7:0] ST_SEL_STOP = 8'h92;
  localparam logic [7:0] ST_SEL_GO   = 8'h90;
  localparam logic [7:0] ST_RESP     = 8'h97;

  localparam logic [7:0] STEP_CMD    = 8'h04;
  localparam logic [7:0] CFG1_INIT   = 8'h07;
  localparam int         CFG1_QUIET  = 6;
  localparam logic [7:0] CHIP_ID     = 8'h04;

  typedef enum logic [3:0] {
    OP_NOP, OP_FLUSH, OP_CHIPRST, OP_BUSRST, OP_XFER, OP_RESP,
    OP_MSGOK, OP_PAD, OP_ATN, OP_SEL, OP_ENSEL, OP_BAD
  } op_e;

  typedef struct packed {
    logic dma;
    op_e  op;
    logic atn;
    logic stop;
  } cmd_t;

endpackage

// File: rtl/scsi_cmd_decode.sv
module scsi_cmd_decode
  import scsi_ctl_pkg::*;
(
  input  logic [7:0] opcode,
  output cmd_t       cmd
);

  always_comb begin
    cmd.dma  = opcode[7];
    cmd.atn  = 1'b0;
    cmd.stop = 1'b0;
    case (opcode[6:0])
      7'h00: cmd.op = OP_NOP;
      7'h01: cmd.op = OP_FLUSH;
      7'h02: cmd.op = OP_CHIPRST;
      7'h03: cmd.op = OP_BUSRST;
      7'h10: cmd.op = OP_XFER;
      7'h11: cmd.op = OP_RESP;
      7'h12: cmd.op = OP_MSGOK;
      7'h18: cmd.op = OP_PAD;
      7'h1a: cmd.op = OP_ATN;
      7'h41: cmd.op = OP_SEL;
      7'h42: begin
        cmd.op  = OP_SEL;
        cmd.atn = 1'b1;
      end
      7'h43: begin
        cmd.op   = OP_SEL;
        cmd.atn  = 1'b1;
        cmd.stop = 1'b1;
      end
      7'h44: cmd.op = OP_ENSEL;
      default: cmd.op = OP_BAD;
    endcase
  end

endmodule

// File: rtl/scsi_byte_fifo.sv
module scsi_byte_fifo #(
  parameter int DEPTH = 16,
  localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1,
  localparam int CNT_W = $clog2(DEPTH + 1)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             flush,
  input  logic             push,
  input  logic [7:0]       din,
  input  logic             pop,
  output logic [7:0]       dout,
  output logic [CNT_W-1:0] count
);

  localparam logic [PTR_W-1:0] LAST = PTR_W'(DEPTH - 1);
  localparam logic [CNT_W-1:0] FULL = CNT_W'(DEPTH);

  logic [7:0]       mem [DEPTH];
  logic [PTR_W-1:0] wptr, rptr;
  logic             do_push, do_pop;

  assign do_push = push && (count != FULL);
  assign do_pop  = pop && (count != '0);
  assign dout    = mem[rptr];

  // storage has no reset so it maps onto plain RAM
  always_ff @(posedge clk) begin
    if (do_push) mem[wptr] <= din;
  end

  always_ff @(posedge clk) begin
    if (rst || flush) begin
      wptr  <= '0;
      rptr  <= '0;
      count <= '0;
    end else begin
      if (do_push) wptr <= (wptr == LAST) ? '0 : wptr + 1'b1;
      if (do_pop)  rptr <= (rptr == LAST) ? '0 : rptr + 1'b1;
      case ({do_push, do_pop})
        2'b10:   count <= count + 1'b1;
        2'b01:   count <= count - 1'b1;
        default: count <= count;
      endcase
    end
  end

endmodule

// File: rtl/scsi_ctl_regs.sv
module scsi_ctl_regs
  import scsi_ctl_pkg::*;
#(
  parameter int ADDR_W     = 8,
  parameter int ADDR_SHIFT = 2,
  parameter int FIFO_DEPTH = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic              wr_en,
  input  logic [7:0]        wr_data,
  input  logic              rd_en,
  output logic [7:0]        rd_data,
  output logic              irq,
  output logic              sel_req,
  output logic              sel_atn,
  output logic              sel_stop,
  output logic [2:0]        sel_target,
  input  logic              sel_done,
  input  logic              sel_present,
  output logic              xfer_req,
  output logic              xfer_dma,
  output logic              xfer_cmd,
  input  logic              xfer_done,
  output logic              resp_req,
  input  logic              resp_done,
  output logic              capture_mode
);

  localparam int CNT_W = $clog2(FIFO_DEPTH + 1);
  localparam logic [ADDR_W-1:0] IDX_MASK = ADDR_W'(4'hF) << ADDR_SHIFT;

  logic [3:0] idx;
  logic       acc_ok, wr_hit, rd_hit, cmd_wr, soft_rst, fifo_flush;
  cmd_t       dec;

  logic [7:0] status_q, cause_q, step_q, cfg1_q, cmd_q;
  logic [7:0] cnt_lo_q, cnt_mid_q, cnt_lo_w, cnt_mid_w;
  logic [2:0] busid_q;
  logic [7:0] hi_q [HI_N];

  logic [7:0]       fifo_out;
  logic [CNT_W-1:0] fifo_cnt;
  logic             fifo_push, fifo_pop;

  assign idx      = bus_addr[ADDR_SHIFT +: 4];
  assign acc_ok   = (bus_addr & ~IDX_MASK) == '0;
  assign wr_hit   = wr_en && acc_ok;
  assign rd_hit   = rd_en && !wr_en && acc_ok;
  assign cmd_wr   = wr_hit && (idx == IX_CMD);
  assign soft_rst = cmd_wr && (dec.op == OP_CHIPRST);
  assign fifo_flush = cmd_wr && ((dec.op == OP_FLUSH) || (dec.op == OP_MSGOK));
  assign fifo_push  = wr_hit && (idx == IX_FIFO);
  assign fifo_pop   = rd_hit && (idx == IX_FIFO);
  assign irq        = status_q[ST_INT];

  scsi_cmd_decode u_dec (
    .opcode (wr_data),
    .cmd    (dec)
  );

  scsi_byte_fifo #(.DEPTH(FIFO_DEPTH)) u_fifo (
    .clk   (clk),
    .rst   (rst || soft_rst),
    .flush (fifo_flush),
    .push  (fifo_push),
    .din   (wr_data),
    .pop   (fifo_pop),
    .dout  (fifo_out),
    .count (fifo_cnt)
  );

  always_ff @(posedge clk) begin
    if (rst || soft_rst) begin
      rd_data      <= '0;
      status_q     <= '0;
      cause_q      <= '0;
      step_q       <= '0;
      cfg1_q       <= CFG1_INIT;
      cmd_q        <= '0;
      cnt_lo_q     <= '0;
      cnt_mid_q    <= '0;
      cnt_lo_w     <= '0;
      cnt_mid_w    <= '0;
      busid_q      <= '0;
      sel_req      <= 1'b0;
      sel_atn      <= 1'b0;
      sel_stop     <= 1'b0;
      sel_target   <= '0;
      xfer_req     <= 1'b0;
      xfer_dma     <= 1'b0;
      xfer_cmd     <= 1'b0;
      resp_req     <= 1'b0;
      capture_mode <= 1'b0;
      for (int k = 0; k < HI_N; k++) hi_q[k] <= (k == HI_ID) ? CHIP_ID : 8'h00;
    end else begin
      sel_req  <= 1'b0;
      xfer_req <= 1'b0;
      resp_req <= 1'b0;

      // ---------------- read side ----------------
      if (rd_hit) begin
        case (idx)
          IX_CNT_LO:  rd_data <= cnt_lo_q;
          IX_CNT_MID: rd_data <= cnt_mid_q;
          IX_FIFO:    rd_data <= (fifo_cnt == '0) ? 8'h00 : fifo_out;
          IX_CMD:     rd_data <= cmd_q;
          IX_STAT:    rd_data <= status_q;
          IX_CAUSE: begin
            rd_data  <= cause_q;
            cause_q  <= '0;
            status_q <= status_q & ST_TC_MASK;
            step_q   <= STEP_CMD;
          end
          IX_STEP:    rd_data <= step_q;
          IX_FLAGS:   rd_data <= 8'(fifo_cnt);
          IX_CFG1:    rd_data <= cfg1_q;
          4'h9, 4'hA: rd_data <= 8'h00;
          default:    rd_data <= hi_q[3'(idx - IX_HI_BASE)];
        endcase
      end

      // ---------------- write side ----------------
      if (wr_hit) begin
        case (idx)
          IX_CNT_LO: begin
            cnt_lo_w        <= wr_data;
            status_q[ST_TC] <= 1'b0;
          end
          IX_CNT_MID: begin
            cnt_mid_w       <= wr_data;
            status_q[ST_TC] <= 1'b0;
          end
          IX_STAT: busid_q <= wr_data[2:0];
          IX_CFG1: cfg1_q  <= wr_data;
          IX_CMD: begin
            cmd_q <= wr_data;
            if (dec.dma && (dec.op != OP_BAD)) begin
              cnt_lo_q  <= cnt_lo_w;
              cnt_mid_q <= cnt_mid_w;
            end
            case (dec.op)
              OP_FLUSH: begin
                cause_q <= CAUSE_DONE;
                step_q  <= '0;
              end
              OP_BUSRST: begin
                cause_q <= CAUSE_BRST;
                if (!cfg1_q[CFG1_QUIET]) status_q[ST_INT] <= 1'b1;
              end
              OP_XFER: begin
                xfer_req     <= 1'b1;
                xfer_dma     <= dec.dma;
                xfer_cmd     <= capture_mode;
                capture_mode <= 1'b0;
                if (dec.dma) status_q[ST_TC] <= 1'b0;
              end
              OP_RESP: resp_req <= 1'b1;
              OP_MSGOK: begin
                cause_q          <= CAUSE_DISC;
                step_q           <= '0;
                status_q[ST_INT] <= 1'b1;
              end
              OP_PAD: begin
                status_q <= ST_TC_MASK;
                cause_q  <= CAUSE_DONE;
                step_q   <= '0;
              end
              OP_SEL: begin
                sel_req    <= 1'b1;
                sel_atn    <= dec.atn;
                sel_stop   <= dec.stop;
                sel_target <= busid_q;
              end
              OP_ENSEL: cause_q <= '0;
              default: ;
            endcase
          end
          default: begin
            if (idx >= IX_HI_BASE) hi_q[3'(idx - IX_HI_BASE)] <= wr_data;
          end
        endcase
      end

      // ---------------- completions ----------------
      if (sel_done) begin
        if (!sel_present) begin
          status_q <= ST_SEL_NONE;
          cause_q  <= CAUSE_DISC;
          step_q   <= '0;
        end else if (sel_stop) begin
          status_q     <= ST_SEL_STOP;
          cause_q      <= CAUSE_SVC | CAUSE_DONE;
          step_q       <= STEP_CMD;
          capture_mode <= 1'b1;
        end else begin
          status_q <= ST_SEL_GO;
          cause_q  <= CAUSE_SVC | CAUSE_DONE;
          step_q   <= STEP_CMD;
        end
      end
      if (xfer_done) begin
        status_q  <= status_q | ST_SEL_GO;
        cause_q   <= CAUSE_SVC;
        step_q    <= '0;
        cnt_lo_q  <= '0;
        cnt_mid_q <= '0;
      end
      if (resp_done) begin
        status_q <= ST_RESP;
        cause_q  <= CAUSE_DONE;
        step_q   <= STEP_CMD;
      end
    end
  end

endmodule

// File: rtl/scsi_ctl_regs_chk.sv
module scsi_ctl_regs_chk #(
  parameter int ADDR_W     = 8,
  parameter int ADDR_SHIFT = 2
) (
  input logic              clk,
  input logic              rst,
  input logic [ADDR_W-1:0] bus_addr,
  input logic              wr_en,
  input logic [7:0]        wr_data,
  input logic              rd_en,
  input logic              irq,
  input logic              sel_req,
  input logic              xfer_req,
  input logic              resp_req,
  input logic              sel_done,
  input logic              xfer_done,
  input logic              resp_done,
  input logic [7:0]        status_q,
  input logic [7:0]        step_q,
  input logic [7:0]        cause_q,
  input logic [7:0]        cfg1_q
);

  localparam logic [ADDR_W-1:0] IDX_MASK = ADDR_W'(4'hF) << ADDR_SHIFT;

  logic [3:0] idx;
  logic       ok, quiet, ack_rd, cmd_w;

  assign idx    = bus_addr[ADDR_SHIFT +: 4];
  assign ok     = (bus_addr & ~IDX_MASK) == '0;
  assign quiet  = !sel_done && !xfer_done && !resp_done;
  assign ack_rd = rd_en && !wr_en && ok && (idx == 4'h5) && quiet;
  assign cmd_w  = wr_en && ok && (idx == 4'h3) && quiet;

  AST_RESET_STATE: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> (cfg1_q == 8'h07 && !irq)); // R1

  AST_ACK_CLEARS: assert property (@(posedge clk) disable iff (rst)
    ack_rd |=> (cause_q == 8'h00 && step_q == 8'h04 && !irq && (status_q & 8'hEF) == 8'h00)); // R4

  AST_BUSRST_QUIET: assert property (@(posedge clk) disable iff (rst)
    (cmd_w && wr_data == 8'h03 && cfg1_q[6] && !irq) |=> !irq); // R7

  AST_REQ_EXCLUSIVE: assert property (@(posedge clk) disable iff (rst)
    $onehot0({sel_req, xfer_req, resp_req})); // R8

  AST_DMA_XFER_TC: assert property (@(posedge clk) disable iff (rst)
    (cmd_w && wr_data == 8'h90) |=> !status_q[4]); // R10

  AST_PAD_STATUS: assert property (@(posedge clk) disable iff (rst)
    (cmd_w && wr_data[6:0] == 7'h18) |=> (status_q == 8'h10 && !irq)); // R12

endmodule

bind scsi_ctl_regs scsi_ctl_regs_chk #(.ADDR_W(ADDR_W), .ADDR_SHIFT(ADDR_SHIFT)) u_chk (
  .clk       (clk),
  .rst       (rst),
  .bus_addr  (bus_addr),
  .wr_en     (wr_en),
  .wr_data   (wr_data),
  .rd_en     (rd_en),
  .irq       (irq),
  .sel_req   (sel_req),
  .xfer_req  (xfer_req),
  .resp_req  (resp_req),
  .sel_done  (sel_done),
  .xfer_done (xfer_done),
  .resp_done (resp_done),
  .status_q  (status_q),
  .step_q    (step_q),
  .cause_q   (cause_q),
  .cfg1_q    (cfg1_q)
);

// File: tb/scsi_ctl_regs_bench.sv
module scsi_ctl_regs_bench;

  localparam int CLK_PERIOD = 10;
  localparam int SH = 2;
  localparam int WATCHDOG = 20000;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic [7:0] bus_addr = '0;
  logic       wr_en = 1'b0, rd_en = 1'b0;
  logic [7:0] wr_data = '0;
  logic [7:0] rd_data;
  logic       irq, sel_req, sel_atn, sel_stop, xfer_req, xfer_dma, xfer_cmd, resp_req, capture_mode;
  logic [2:0] sel_target;
  logic       sel_done = 1'b0, sel_present = 1'b0, xfer_done = 1'b0, resp_done = 1'b0;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  scsi_ctl_regs #(.ADDR_W(8), .ADDR_SHIFT(SH), .FIFO_DEPTH(16)) u_scsi_ctl_regs (
    .clk(clk), .rst(rst), .bus_addr(bus_addr), .wr_en(wr_en), .wr_data(wr_data),
    .rd_en(rd_en), .rd_data(rd_data), .irq(irq),
    .sel_req(sel_req), .sel_atn(sel_atn), .sel_stop(sel_stop), .sel_target(sel_target),
    .sel_done(sel_done), .sel_present(sel_present),
    .xfer_req(xfer_req), .xfer_dma(xfer_dma), .xfer_cmd(xfer_cmd), .xfer_done(xfer_done),
    .resp_req(resp_req), .resp_done(resp_done), .capture_mode(capture_mode)
  );

  task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr_raw(input logic [7:0] a, input logic [7:0] v);
    @(negedge clk);
    bus_addr = a; wr_data = v; wr_en = 1'b1;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic wr(input logic [3:0] a, input logic [7:0] v);
    wr_raw(8'(a) << SH, v);
  endtask

  task automatic cmd(input logic [7:0] v);
    wr(4'h3, v);
  endtask

  task automatic rd(input logic [3:0] a, output logic [7:0] v);
    @(negedge clk);
    bus_addr = 8'(a) << SH; rd_en = 1'b1;
    @(negedge clk);
    rd_en = 1'b0;
    v = rd_data;
  endtask

  task automatic rd_chk(input string req, input logic [3:0] a, input logic [7:0] exp);
    logic [7:0] v;
    rd(a, v);
    chk(req, v, exp);
  endtask

  task automatic pulse_sel(input logic present);
    @(negedge clk);
    sel_done = 1'b1; sel_present = present;
    @(negedge clk);
    sel_done = 1'b0; sel_present = 1'b0;
  endtask

  task automatic pulse_xfer();
    @(negedge clk); xfer_done = 1'b1;
    @(negedge clk); xfer_done = 1'b0;
  endtask

  task automatic pulse_resp();
    @(negedge clk); resp_done = 1'b1;
    @(negedge clk); resp_done = 1'b0;
  endtask

  task automatic t_reset();
    rd_chk("R1 step", 4'h6, 8'h00);
    rd_chk("R1 cfg1", 4'h8, 8'h07);
    rd_chk("R1 count-high id", 4'hE, 8'h04);
    rd_chk("R1 status", 4'h4, 8'h00);
    rd_chk("R1 flags", 4'h7, 8'h00);
    rd_chk("R1 count low", 4'h0, 8'h00);
    rd_chk("R1 cause", 4'h5, 8'h00);
    chk("R1 irq", 8'(irq), 8'h00);
  endtask

  task automatic t_addr();
    wr(4'h4, 8'hFF);
    rd_chk("R2 bus-id write not in status", 4'h4, 8'h00);
    wr(4'h9, 8'h55);
    rd_chk("R2 index 9 reads zero", 4'h9, 8'h00);
    wr(4'hB, 8'hA5);
    rd_chk("R2 index 11 readback", 4'hB, 8'hA5);
    wr_raw((8'h8 << SH) | 8'h01, 8'h40);
    rd_chk("R2 misaligned write ignored", 4'h8, 8'h07);
    wr_raw((8'h8 << SH) | 8'h80, 8'h40);
    rd_chk("R2 upper-bit write ignored", 4'h8, 8'h07);
  endtask

  task automatic t_counts();
    cmd(8'h18);
    rd_chk("R3 tc set by pad", 4'h4, 8'h10);
    wr(4'h0, 8'h34);
    rd_chk("R3 count write clears tc", 4'h4, 8'h00);
    wr(4'h1, 8'h12);
    rd_chk("R3 count not reloaded yet", 4'h0, 8'h00);
    cmd(8'h80);
    rd_chk("R3 reload low", 4'h0, 8'h34);
    rd_chk("R3 reload mid", 4'h1, 8'h12);
    rd_chk("R2 command readback", 4'h3, 8'h80);
  endtask

  task automatic t_busrst();
    cmd(8'h03);
    chk("R7 bus reset raises irq", 8'(irq), 8'h01);
    rd_chk("R5 status int flag", 4'h4, 8'h80);
    rd_chk("R4 ack returns old cause", 4'h5, 8'h80);
    chk("R4 irq dropped", 8'(irq), 8'h00);
    rd_chk("R4 step forced", 4'h6, 8'h04);
    rd_chk("R4 status cleared", 4'h4, 8'h00);
    wr(4'h8, 8'h47);
    cmd(8'h03);
    chk("R7 masked bus reset", 8'(irq), 8'h00);
    rd_chk("R7 masked cause", 4'h5, 8'h80);
    wr(4'h8, 8'h07);
  endtask

  task automatic t_fifo_flush();
    wr(4'h2, 8'h11); wr(4'h2, 8'h22); wr(4'h2, 8'h33);
    rd_chk("R14 fill count", 4'h7, 8'h03);
    rd_chk("R14 first byte", 4'h2, 8'h11);
    rd_chk("R14 count after pop", 4'h7, 8'h02);
    cmd(8'h01);
    rd_chk("R6 flush empties", 4'h7, 8'h00);
    rd_chk("R6 flush step", 4'h6, 8'h00);
    chk("R6 flush no irq", 8'(irq), 8'h00);
    rd_chk("R6 flush cause", 4'h5, 8'h08);
    wr(4'h2, 8'h44);
    cmd(8'h12);
    chk("R6 msg accepted irq", 8'(irq), 8'h01);
    rd_chk("R6 msg accepted empties", 4'h7, 8'h00);
    rd_chk("R6 msg accepted step", 4'h6, 8'h00);
    rd_chk("R6 msg accepted cause", 4'h5, 8'h20);
  endtask

  task automatic t_fifo_full();
    for (int i = 0; i < 17; i++) wr(4'h2, 8'(8'h40 + i));
    rd_chk("R14 full count", 4'h7, 8'h10);
    for (int i = 0; i < 16; i++) rd_chk("R14 order", 4'h2, 8'(8'h40 + i));
    rd_chk("R14 drained", 4'h7, 8'h00);
    rd_chk("R14 empty read", 4'h2, 8'h00);
  endtask

  task automatic t_sel_absent();
    wr(4'h4, 8'h05);
    cmd(8'h42);
    chk("R8 sel_req", 8'(sel_req), 8'h01);
    chk("R8 target", 8'(sel_target), 8'h05);
    chk("R8 atn", 8'(sel_atn), 8'h01);
    chk("R8 stop", 8'(sel_stop), 8'h00);
    @(negedge clk);
    chk("R8 one-cycle pulse", 8'(sel_req), 8'h00);
    pulse_sel(1'b0);
    chk("R8 absent irq", 8'(irq), 8'h01);
    rd_chk("R8 absent status", 4'h4, 8'h80);
    rd_chk("R8 absent step", 4'h6, 8'h00);
    rd_chk("R8 absent cause", 4'h5, 8'h20);
  endtask

  task automatic t_sel_present();
    cmd(8'h01);
    cmd(8'h43);
    chk("R8 stop flag", 8'(sel_stop), 8'h01);
    pulse_sel(1'b1);
    rd_chk("R9 stop status", 4'h4, 8'h92);
    rd_chk("R9 stop step", 4'h6, 8'h04);
    chk("R9 capture set", 8'(capture_mode), 8'h01);
    rd_chk("R9 stop cause", 4'h5, 8'h18);
    cmd(8'h41);
    chk("R8 plain select no atn", 8'(sel_atn), 8'h00);
    pulse_sel(1'b1);
    rd_chk("R9 go status", 4'h4, 8'h90);
    rd_chk("R9 go cause", 4'h5, 8'h18);
  endtask

  task automatic t_xfer();
    cmd(8'h10);
    chk("R10 xfer_req", 8'(xfer_req), 8'h01);
    chk("R10 xfer_cmd from capture", 8'(xfer_cmd), 8'h01);
    chk("R10 no dma", 8'(xfer_dma), 8'h00);
    chk("R10 capture cleared", 8'(capture_mode), 8'h00);
    wr(4'h0, 8'h08);
    cmd(8'h18);
    cmd(8'h90);
    chk("R10 dma flag", 8'(xfer_dma), 8'h01);
    chk("R10 no command bytes", 8'(xfer_cmd), 8'h00);
    rd_chk("R10 dma clears tc", 4'h4, 8'h00);
    rd_chk("R3 dma reload", 4'h0, 8'h08);
    pulse_xfer();
    chk("R10 done irq", 8'(irq), 8'h01);
    rd_chk("R10 done status", 4'h4, 8'h90);
    rd_chk("R10 count low zeroed", 4'h0, 8'h00);
    rd_chk("R10 count mid zeroed", 4'h1, 8'h00);
    rd_chk("R10 done step", 4'h6, 8'h00);
    rd_chk("R10 done cause", 4'h5, 8'h10);
  endtask

  task automatic t_resp();
    cmd(8'h11);
    chk("R11 resp_req", 8'(resp_req), 8'h01);
    pulse_resp();
    rd_chk("R11 status", 4'h4, 8'h97);
    chk("R11 irq", 8'(irq), 8'h01);
    rd_chk("R11 cause", 4'h5, 8'h08);
    rd_chk("R4 keeps only tc", 4'h4, 8'h10);
  endtask

  task automatic t_misc();
    cmd(8'h03);
    cmd(8'h18);
    chk("R12 pad drops irq", 8'(irq), 8'h00);
    rd_chk("R12 pad step", 4'h6, 8'h00);
    rd_chk("R12 pad cause", 4'h5, 8'h08);
    cmd(8'h03);
    cmd(8'h44);
    rd_chk("R12 enable selection cause", 4'h5, 8'h00);
    wr(4'h0, 8'h99);
    cmd(8'h18);
    cmd(8'hFF);
    rd_chk("R12 unknown keeps status", 4'h4, 8'h10);
    rd_chk("R12 unknown no reload", 4'h0, 8'h00);
    rd_chk("R12 unknown keeps step", 4'h6, 8'h00);
    cmd(8'h00);
    cmd(8'h1A);
    rd_chk("R12 nop/atn keep status", 4'h4, 8'h10);
    rd_chk("R12 command readback", 4'h3, 8'h1A);
    rd_chk("R12 nop/atn keep cause", 4'h5, 8'h08);
  endtask

  task automatic t_chiprst();
    wr(4'h8, 8'h41);
    wr(4'hE, 8'h77);
    cmd(8'h12);
    wr(4'h2, 8'h5A);
    cmd(8'h02);
    chk("R13 irq low", 8'(irq), 8'h00);
    rd_chk("R13 cfg1", 4'h8, 8'h07);
    rd_chk("R13 id", 4'hE, 8'h04);
    rd_chk("R13 fifo empty", 4'h7, 8'h00);
    rd_chk("R13 status", 4'h4, 8'h00);
    rd_chk("R13 command", 4'h3, 8'h00);
    rd_chk("R13 upper bank", 4'hB, 8'h00);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    t_reset();
    t_addr();
    t_counts();
    t_busrst();
    t_fifo_flush();
    t_fifo_full();
    t_sel_absent();
    t_sel_present();
    t_xfer();
    t_resp();
    t_misc();
    t_chiprst();
    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    repeat (WATCHDOG) @(posedge clk);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

endmodule